// File: doc/BRIEF.md
# Nesting Interrupt Controller with Split Priority Drop

This block gathers sixteen level-sensitive interrupt inputs and drives one request line towards a processor core. Each source has an enable bit and an 8-bit priority number, where a smaller number is more urgent. A global priority mask and the priority of the interrupt currently being serviced decide which inputs may raise the request. Inputs are never latched: a source is pending only while its input is high. A handler that leaves its device still requesting will therefore be interrupted again.

Software reaches the controller through a 32-bit register port. It acknowledges an interrupt by reading a register that returns the winning source ID. That read marks the source active and pushes its priority onto a running-priority stack, so only a more urgent source can pre-empt the handler. An end-of-interrupt write pops the stack. In the combined mode it also clears the source's active bit. In the split mode it only drops the priority, and a separate deactivate write ends the service. This lets a handler reopen the core to less urgent work before its device is fully serviced. Software polls a status register that holds every source's active bit to learn when servicing has finished.

Register map (byte offsets): 0x00 control (bit 0 = split mode), 0x04 priority mask (bits 7:0), 0x08 enables (bit i = source i), 0x0C acknowledge (read), 0x10 end-of-interrupt (write ID), 0x14 deactivate (write ID), 0x18 active status (read), 0x1C running priority (read), 0x40 + 4*i priority of source i (bits 7:0).

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, irq_out is low, no source is active, the running priority reads 0xFF, all enables read 0, the mask reads 0xFF, every source priority reads 0xF0 and the control register reads 0.
- R2: A source is signalled only while its input is high, its enable bit is 1, it is not active, and its priority is strictly lower than both the running priority and the mask; irq_out is registered and is high when any source is signalled.
- R3: A source whose enable bit is 0 never causes irq_out to go high and is never returned by an acknowledge read, whatever its input level.
- R4: A priority of 0xF0 or above is never signalled, even when the mask is 0xFF.
- R5: A read of offset 0x0C with a signalled source returns the ID of the source with the lowest priority number, ties going to the lowest ID; it marks that source active and makes its priority the running priority.
- R6: A read of offset 0x0C with no signalled source returns 1023 and changes no active bit and no running priority.
- R7: With control bit 0 at 0, a write of an ID to offset 0x10 restores the previous running priority and clears that source's active bit.
- R8: With control bit 0 at 1, a write to offset 0x10 only restores the previous running priority; a write of an ID to offset 0x14 clears that source's active bit.
- R9: A source whose input stays high while it is active is not signalled; once its active bit clears and the running priority allows it, it is signalled again.
- R10: A read of offset 0x18 returns the active bits, bit i for source i.
- R11: The running-priority stack holds 8 entries; while it is full no source is signalled; an end-of-interrupt write with an empty stack changes nothing.
- R12: The port answers every selected access with bus_ready high one cycle later; read data appears in that cycle, and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | 16 | Level inputs of the sources, bit i = source i |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high after a read |
| bus_ready | output | 1 | Access completed, one cycle after bus_sel |
| irq_out | output | 1 | Interrupt request to the core |

## Verification
An access takes effect at the rising edge where bus_sel is sampled, and its read data and bus_ready are due one cycle later. The bench drives each access from a falling edge and reads the result at the next falling edge. irq_out is a register fed from state that is itself registered, so it answers a level change or a bus operation at the second rising edge after the stimulus. Every check on irq_out therefore waits two full cycles and samples at a falling edge. Acknowledge results are compared with a winner the bench computes arithmetically from its own copy of levels, enables, priorities, mask and expected running priority.

// File: rtl/irqn_pkg.sv
package irqn_pkg;
  // Byte offsets of the register port
  localparam int unsigned OFS_CTRL      = 'h00;
  localparam int unsigned OFS_PMASK     = 'h04;
  localparam int unsigned OFS_ENABLE    = 'h08;
  localparam int unsigned OFS_IACK      = 'h0C;
  localparam int unsigned OFS_EOI       = 'h10;
  localparam int unsigned OFS_DEACT     = 'h14;
  localparam int unsigned OFS_ACTIVE    = 'h18;
  localparam int unsigned OFS_RUNPRI    = 'h1C;
  localparam int unsigned OFS_PRIO_BASE = 'h40;
  // ID returned when nothing can be acknowledged
  localparam int unsigned SPURIOUS_ID   = 1023;
endpackage

// File: rtl/irqn_regs.sv
module irqn_regs
  import irqn_pkg::*;
#(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [N_SRC-1:0]         enable,
  output logic [N_SRC*PRIO_W-1:0]  prio_flat,
  output logic [PRIO_W-1:0]        pmask,
  output logic                     split_mode,
  output logic                     rd_hit,
  output logic [DATA_W-1:0]        rd_data
);
  localparam int unsigned ID_W    = $clog2(N_SRC);
  localparam int unsigned IDLE_I  = (1 << PRIO_W) - 16;
  localparam logic [PRIO_W-1:0] IDLE_P = IDLE_I[PRIO_W-1:0];

  logic              hit_ctrl, hit_mask, hit_en, hit_prio;
  logic [ADDR_W-1:0] poff;
  logic [ID_W-1:0]   pidx;
  logic              unused_hi;

  assign unused_hi = ^wdata[DATA_W-1:N_SRC];

  assign hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
  assign hit_mask = (addr == ADDR_W'(OFS_PMASK));
  assign hit_en   = (addr == ADDR_W'(OFS_ENABLE));
  assign poff     = addr - ADDR_W'(OFS_PRIO_BASE);
  assign hit_prio = (addr >= ADDR_W'(OFS_PRIO_BASE)) &&
                    (poff < ADDR_W'(4 * N_SRC)) && (poff[1:0] == 2'b00);
  assign pidx     = poff[ID_W+1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      split_mode <= 1'b0;
      pmask      <= '1;
      enable     <= '0;
    end else if (wr_en) begin
      if (hit_ctrl) split_mode <= wdata[0];
      if (hit_mask) pmask      <= wdata[PRIO_W-1:0];
      if (hit_en)   enable     <= wdata[N_SRC-1:0];
    end
  end

  // One priority register per source
  for (genvar g = 0; g < N_SRC; g++) begin : g_prio
    logic [PRIO_W-1:0] p_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        p_q <= IDLE_P;
      end else if (wr_en && hit_prio && (pidx == ID_W'(g))) begin
        p_q <= wdata[PRIO_W-1:0];
      end
    end
    assign prio_flat[g*PRIO_W +: PRIO_W] = p_q;
  end

  always_comb begin
    rd_hit  = hit_ctrl | hit_mask | hit_en | hit_prio;
    rd_data = '0;
    if (hit_ctrl)      rd_data = DATA_W'(split_mode);
    else if (hit_mask) rd_data = DATA_W'(pmask);
    else if (hit_en)   rd_data = DATA_W'(enable);
    else if (hit_prio) rd_data = DATA_W'(prio_flat[pidx*PRIO_W +: PRIO_W]);
  end
endmodule

// File: rtl/irqn_arbiter.sv
module irqn_arbiter #(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned ID_W   = 4
) (
  input  logic [N_SRC-1:0]        req,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  output logic                    any,
  output logic [ID_W-1:0]         id,
  output logic [PRIO_W-1:0]       best
);
  // Scan from the top ID down; "<=" lets a lower ID win a tie.
  always_comb begin
    any  = 1'b0;
    id   = '0;
    best = '1;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i] && (!any || (prio_flat[i*PRIO_W +: PRIO_W] <= best))) begin
        any  = 1'b1;
        id   = ID_W'(i);
        best = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irqn_prio_stack.sv
module irqn_prio_stack #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned PRIO_W = 8,
  localparam int unsigned SP_W  = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] push_val,
  output logic [PRIO_W-1:0] top,
  output logic              empty,
  output logic              full,
  output logic [SP_W-1:0]   depth
);
  logic [PRIO_W-1:0] mem [DEPTH];
  logic [SP_W-1:0]   cnt;
  logic [PTR_W-1:0]  top_idx;

  assign empty   = (cnt == '0);
  assign full    = (cnt == SP_W'(DEPTH));
  assign depth   = cnt;
  assign top_idx = cnt[PTR_W-1:0] - PTR_W'(1);

  // Storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push && !full) mem[cnt[PTR_W-1:0]] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (push && !full)  cnt <= cnt + SP_W'(1);
    else if (pop && !empty)  cnt <= cnt - SP_W'(1);
  end

  assign top = empty ? '1 : mem[top_idx];
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irqn_pkg::*;
#(
  parameter int unsigned N_SRC       = 16,
  parameter int unsigned PRIO_W      = 8,
  parameter int unsigned STACK_DEPTH = 8,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_lvl,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              irq_out
);
  localparam int unsigned ID_W   = $clog2(N_SRC);
  localparam int unsigned SP_W   = $clog2(STACK_DEPTH + 1);
  localparam int unsigned IDLE_I = (1 << PRIO_W) - 16;
  localparam logic [PRIO_W-1:0] IDLE_P = IDLE_I[PRIO_W-1:0];

  logic [N_SRC-1:0]         enable, active, active_nx, elig;
  logic [N_SRC*PRIO_W-1:0]  prio_flat;
  logic [PRIO_W-1:0]        pmask, top_prio, win_prio;
  logic                     split_mode, reg_hit;
  logic [DATA_W-1:0]        reg_rd, rd_val;
  logic                     stk_empty, stk_full;
  logic [SP_W-1:0]          stk_depth;
  logic                     win_any;
  logic [ID_W-1:0]          win_id, wid;
  logic                     is_rd, is_wr, wid_ok;
  logic                     ack_go, eoi_go, deact_go;
  logic                     irq_q;

  irqn_regs #(
    .N_SRC(N_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_regs (
    .clk(clk), .rst(rst), .wr_en(is_wr), .addr(bus_addr), .wdata(bus_wdata),
    .enable(enable), .prio_flat(prio_flat), .pmask(pmask),
    .split_mode(split_mode), .rd_hit(reg_hit), .rd_data(reg_rd)
  );

  irqn_prio_stack #(
    .DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W)
  ) i_stack (
    .clk(clk), .rst(rst), .push(ack_go), .pop(eoi_go), .push_val(win_prio),
    .top(top_prio), .empty(stk_empty), .full(stk_full), .depth(stk_depth)
  );

  // Per-source eligibility: level, enable, not active, and below both limits
  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    logic [PRIO_W-1:0] p;
    assign p = prio_flat[g*PRIO_W +: PRIO_W];
    assign elig[g] = src_lvl[g] & enable[g] & ~active[g] & ~stk_full &
                     (p < top_prio) & (p < pmask) & (p < IDLE_P);
  end

  irqn_arbiter #(
    .N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)
  ) i_arb (
    .req(elig), .prio_flat(prio_flat), .any(win_any), .id(win_id), .best(win_prio)
  );

  assign is_rd    = bus_sel & ~bus_wr;
  assign is_wr    = bus_sel & bus_wr;
  assign wid      = bus_wdata[ID_W-1:0];
  assign wid_ok   = (bus_wdata < DATA_W'(N_SRC));
  assign ack_go   = is_rd && (bus_addr == ADDR_W'(OFS_IACK)) && win_any;
  assign eoi_go   = is_wr && (bus_addr == ADDR_W'(OFS_EOI)) && !stk_empty;
  assign deact_go = is_wr && (bus_addr == ADDR_W'(OFS_DEACT)) && wid_ok;

  always_comb begin
    active_nx = active;
    if (ack_go) active_nx[win_id] = 1'b1;
    if (eoi_go && !split_mode && wid_ok) active_nx[wid] = 1'b0;
    if (deact_go) active_nx[wid] = 1'b0;
  end

  always_comb begin
    rd_val = '0;
    if (reg_hit)
      rd_val = reg_rd;
    else if (bus_addr == ADDR_W'(OFS_IACK))
      rd_val = win_any ? DATA_W'(win_id) : DATA_W'(SPURIOUS_ID);
    else if (bus_addr == ADDR_W'(OFS_ACTIVE))
      rd_val = DATA_W'(active);
    else if (bus_addr == ADDR_W'(OFS_RUNPRI))
      rd_val = DATA_W'(top_prio);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= '0;
      irq_q     <= 1'b0;
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      active    <= active_nx;
      irq_q     <= win_any;
      bus_ready <= bus_sel;
      if (is_rd) bus_rdata <= rd_val;
    end
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/irqn_chk.sv
module irqn_chk
  import irqn_pkg::*;
#(
  parameter int unsigned N_SRC       = 16,
  parameter int unsigned STACK_DEPTH = 8,
  parameter int unsigned ADDR_W      = 8,
  localparam int unsigned ID_W       = $clog2(N_SRC),
  localparam int unsigned SP_W       = $clog2(STACK_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_out,
  input logic [N_SRC-1:0]  src_lvl,
  input logic [N_SRC-1:0]  enable,
  input logic [N_SRC-1:0]  active,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              win_any,
  input logic [ID_W-1:0]   win_id,
  input logic              ack_go,
  input logic              eoi_go,
  input logic              split_mode,
  input logic [ID_W-1:0]   wid,
  input logic              wid_ok,
  input logic              stk_full,
  input logic              stk_empty,
  input logic [SP_W-1:0]   stk_depth
);
  // R3
  enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|(src_lvl & enable & ~active)));

  // R5
  ack_marks_chk: assert property (@(posedge clk) disable iff (rst)
    ack_go |=> active[$past(win_id)] && (stk_depth == $past(stk_depth) + SP_W'(1)));

  // R6
  spurious_still_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_IACK)) && !win_any)
    |=> $stable(active) && $stable(stk_depth));

  // R7
  eoi_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_go && !split_mode && wid_ok) |=> !active[$past(wid)]);

  // R8
  split_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_go && split_mode)
    |=> $stable(active) && (stk_depth == $past(stk_depth) - SP_W'(1)));

  // R11
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    stk_depth <= SP_W'(STACK_DEPTH));

  // R11
  full_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    stk_full |=> !irq_out);

  // R11
  empty_eoi_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_EOI)) && stk_empty)
    |=> $stable(active) && $stable(stk_depth));
endmodule

bind irq_nest_ctrl irqn_chk #(
  .N_SRC(N_SRC), .STACK_DEPTH(STACK_DEPTH), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rst(rst), .irq_out(irq_out), .src_lvl(src_lvl), .enable(enable),
  .active(active), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .win_any(win_any), .win_id(win_id), .ack_go(ack_go), .eoi_go(eoi_go),
  .split_mode(split_mode), .wid(wid), .wid_ok(wid_ok), .stk_full(stk_full),
  .stk_empty(stk_empty), .stk_depth(stk_depth)
);

// File: tb/test_irq_nest_ctrl.sv
module test_irq_nest_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam logic [7:0] A_CTRL = 8'h00, A_MASK = 8'h04, A_EN = 8'h08, A_IACK = 8'h0C,
                         A_EOI = 8'h10, A_DEACT = 8'h14, A_ACT = 8'h18, A_RUN = 8'h1C,
                         A_PRIO = 8'h40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] lvl = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready, irq_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;
  int pr [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_nest_ctrl i_irq_nest_ctrl (
    .clk(clk), .rst(rst), .src_lvl(lvl), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .irq_out(irq_out)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read_chk(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(tag, d, exp);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic set_prio(int i, int p);
    bus_write(A_PRIO + 8'(4 * i), 32'(p));
    pr[i] = p;
  endtask

  // Winner per the requirements: lowest number, ties to lowest ID, 0xF0 idle
  function automatic int ref_winner(logic [15:0] l, logic [15:0] en, logic [15:0] act,
                                    int runp, int mask);
    int best = 1023;
    int bp = 256;
    for (int i = 0; i < NS; i++) begin
      if (l[i] && en[i] && !act[i] && pr[i] < runp && pr[i] < mask &&
          pr[i] < 240 && pr[i] < bp) begin
        best = i;
        bp = pr[i];
      end
    end
    return best;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [15:0] pat;
    int exp;
    for (int i = 0; i < NS; i++) pr[i] = 240;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", 32'(irq_out), 0);
    read_chk("R1 active", A_ACT, 0);
    check("R12 ready", 32'(bus_ready), 1);
    read_chk("R1 runpri", A_RUN, 32'hFF);
    read_chk("R1 enable", A_EN, 0);
    read_chk("R1 mask", A_MASK, 32'hFF);
    read_chk("R1 ctrl", A_CTRL, 0);
    read_chk("R1 prio5", A_PRIO + 8'd20, 32'hF0);
    read_chk("R12 unmapped", 8'h30, 0);
    @(negedge clk);
    check("R12 ready drops", 32'(bus_ready), 0);

    // R3: all levels high, nothing enabled
    for (int i = 0; i < NS; i++) set_prio(i, 16);
    lvl = 16'hFFFF;
    settle();
    check("R3 irq disabled", 32'(irq_out), 0);
    read_chk("R6 spurious", A_IACK, 1023);
    read_chk("R6 active kept", A_ACT, 0);
    read_chk("R6 runpri kept", A_RUN, 32'hFF);

    // R3: one enable at a time, with and without its own level
    for (int i = 0; i < NS; i++) begin
      bus_write(A_EN, 32'(1 << i));
      lvl = ~(16'(1) << i);
      settle();
      check("R3 own level low", 32'(irq_out), 0);
      lvl = 16'hFFFF;
      settle();
      check("R2 single enable", 32'(irq_out), 1);
      read_chk("R5 single ack", A_IACK, 32'(i));
      bus_write(A_EOI, 32'(i));
    end
    lvl = '0;

    // R5/R2/R4/R7: arbitration sweep with ties and idle levels
    for (int i = 0; i < NS; i++) set_prio(i, ((i * 5) % 4) * 48 + 16);
    set_prio(13, 240);
    set_prio(6, 248);
    bus_write(A_EN, 32'hFFFF);
    pat = 16'hACE1;
    for (int k = 0; k < 48; k++) begin
      pat = {pat[14:0], pat[15] ^ pat[13] ^ pat[12] ^ pat[10]};
      lvl = (k % 7 == 0) ? (pat & 16'h2040) : pat;
      settle();
      exp = ref_winner(lvl, 16'hFFFF, 16'h0, 255, 255);
      check("R2 irq sweep", 32'(irq_out), 32'(exp != 1023));
      read_chk("R5 ack sweep", A_IACK, 32'(exp));
      if (exp != 1023) begin
        read_chk("R5 runpri", A_RUN, 32'(pr[exp]));
        bus_write(A_EOI, 32'(exp));
        read_chk("R7 cleared", A_ACT, 0);
        read_chk("R7 runpri back", A_RUN, 32'hFF);
      end
    end
    lvl = '0;

    // R2/R4: mask sweep
    bus_write(A_EN, 32'h4);
    set_prio(2, 64);
    lvl = 16'h4;
    for (int m = 0; m < 256; m += 17) begin
      bus_write(A_MASK, 32'(m));
      settle();
      check("R2 mask", 32'(irq_out), 32'(64 < m));
    end
    bus_write(A_MASK, 32'hFF);
    set_prio(2, 240);
    settle();
    check("R4 idle masked", 32'(irq_out), 0);
    lvl = '0;

    // R5/R2/R10: nesting
    for (int i = 0; i < NS; i++) set_prio(i, 240);
    set_prio(3, 128); set_prio(7, 96); set_prio(5, 64); set_prio(9, 64);
    bus_write(A_EN, 32'h02A8);
    lvl = 16'h0008;
    read_chk("R5 nest ack3", A_IACK, 3);
    lvl = 16'h0088;
    settle();
    check("R2 preempt 7", 32'(irq_out), 1);
    read_chk("R5 nest ack7", A_IACK, 7);
    lvl = 16'h00A8;
    read_chk("R5 nest ack5", A_IACK, 5);
    read_chk("R10 active", A_ACT, 32'h00A8);
    read_chk("R5 runpri 40", A_RUN, 32'h40);
    lvl = 16'h02A8;
    settle();
    check("R2 tie no preempt", 32'(irq_out), 0);
    lvl = '0;
    bus_write(A_EOI, 5);
    read_chk("R7 pop 60", A_RUN, 32'h60);
    bus_write(A_EOI, 7);
    read_chk("R7 pop 80", A_RUN, 32'h80);
    bus_write(A_EOI, 3);
    read_chk("R10 none", A_ACT, 0);

    // R8/R9: split mode
    bus_write(A_CTRL, 1);
    set_prio(4, 32);
    bus_write(A_EN, 32'h10);
    lvl = 16'h10;
    read_chk("R8 ack4", A_IACK, 4);
    bus_write(A_EOI, 4);
    read_chk("R8 runpri dropped", A_RUN, 32'hFF);
    read_chk("R8 still active", A_ACT, 32'h10);
    settle();
    check("R9 active pending quiet", 32'(irq_out), 0);
    bus_write(A_DEACT, 4);
    read_chk("R8 deactivated", A_ACT, 0);
    settle();
    check("R9 resignal", 32'(irq_out), 1);
    read_chk("R8 ack4 again", A_IACK, 4);
    bus_write(A_DEACT, 4);
    settle();
    check("R2 running blocks self", 32'(irq_out), 0);
    bus_write(A_EOI, 4);
    settle();
    check("R9 after drop", 32'(irq_out), 1);
    bus_write(A_CTRL, 0);
    read_chk("R9 ack combined", A_IACK, 4);
    settle();
    check("R9 quiet while active", 32'(irq_out), 0);
    bus_write(A_EOI, 4);
    settle();
    check("R9 level still high", 32'(irq_out), 1);
    lvl = '0;
    settle();
    check("R2 level low", 32'(irq_out), 0);

    // R11: fill the stack
    for (int k = 0; k < 8; k++) set_prio(k, 224 - 16 * k);
    set_prio(8, 0);
    bus_write(A_EN, 32'h1FF);
    for (int k = 0; k < 8; k++) begin
      lvl[k] = 1'b1;
      read_chk("R11 fill ack", A_IACK, 32'(k));
    end
    read_chk("R11 top", A_RUN, 32'h70);
    lvl[8] = 1'b1;
    settle();
    check("R11 full quiet", 32'(irq_out), 0);
    read_chk("R11 full spurious", A_IACK, 1023);
    lvl = 16'h100;
    for (int k = 7; k >= 0; k--) bus_write(A_EOI, 32'(k));
    read_chk("R11 emptied", A_RUN, 32'hFF);
    settle();
    check("R11 free again", 32'(irq_out), 1);
    bus_write(A_CTRL, 1);
    read_chk("R11 ack8", A_IACK, 8);
    bus_write(A_EOI, 8);
    bus_write(A_CTRL, 0);
    bus_write(A_EOI, 8);
    read_chk("R11 empty eoi ignored", A_ACT, 32'h100);
    read_chk("R11 empty runpri", A_RUN, 32'hFF);
    bus_write(A_DEACT, 8);
    read_chk("R8 deact mode0", A_ACT, 0);
    lvl = '0;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end
endmodule